// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block turns per-phase high-side and low-side PWM commands into gate-enable signals for two independent half-bridge phases. Each raw command first passes a deglitch filter that discards pulses shorter than a set number of clock cycles. A decoder then maps the filtered pair onto one of three targets: high switch on, low switch on, or both off. A per-phase state machine moves between those targets and never lets the two switches of one phase be on together. Every changeover from one switch to the other passes through a dead interval whose length comes from a cycle-count input.

A shared polarity bit selects how the low-side command is read. With the bit clear, the low-side command is active high. With it set, the low-side command is active low. In that setting the two inputs of a phase may be tied to one control line, and the block then produces complementary drive with the dead interval placed on every edge. A per-phase force-off input from the fault logic overrides everything else. After force-off, and after reset, a phase comes back only through a full dead interval.

The state machine has four states. `ST_DEAD` holds both gates off while counting. `ST_OFF` is the settled state with both gates off. `ST_HI` drives the high gate and `ST_LO` drives the low gate. The transitions are:
- Reset and force-off lead to `ST_DEAD`.
- `ST_DEAD` moves to the state of its pending target once the count completes.
- If the target changes during `ST_DEAD`, the count restarts toward the new target.
- `ST_OFF` moves to `ST_HI` or `ST_LO` on the next clock.
- `ST_HI` and `ST_LO` return to `ST_DEAD` as soon as the target differs from their own.

Top module: `hb_cmd_top`

## Requirements
- R1: With `inv_mode`=0, filtered commands (hi,lo) map as follows: (0,0) gives both gates off, (1,0) gives `gate_hi` on, and (0,1) gives `gate_lo` on.
- R2: With `inv_mode`=1, (0,0) gives `gate_lo` on, (0,1) gives both off, (1,1) gives `gate_hi` on, and (1,0) gives both off.
- R3: When the high command and the effective low command of a phase are both true, both gates of that phase are off, and `gate_hi` and `gate_lo` of a phase are never high together.
- R4: When a phase changes from one switch to the other, both gates stay off for exactly the effective deadtime, counted in clock cycles. This holds in both directions.
- R5: The effective deadtime is `dt_cycles` clamped to the range [DT_MIN, DT_MAX]. With the defaults, a value of 0 or 5 gives 20 cycles and a value of 250 gives 200 cycles.
- R6: A command pulse shorter than GLITCH_CYC cycles (default 7) leaves the gates unchanged. A pulse of exactly GLITCH_CYC cycles is accepted.
- R7: With `inv_mode`=1 and the same level applied to both inputs of a phase, the gates switch complementarily, with the full deadtime on both edges.
- R8: The two phases are independent: commands and force-off on one phase do not disturb the other. The same stimulus on both phases changes both outputs in the same cycle.
- R9: If the target changes while a dead interval is running, the count restarts from the clock edge that sees the new target.
- R10: During reset, and from the clock edge after `force_off` is sampled high, both gates of the phase are off. After `force_off` is released, the gates stay off for the effective deadtime, counted from the last edge that sampled it high.
- R11: From a settled both-off state, a command change shows at the gate output GLITCH_CYC+1 clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_mode | input | 1 | 1: low-side command is active low |
| dt_cycles | input | DT_W | Requested deadtime in clock cycles |
| cmd_hi | input | NPH | High-side PWM command per phase |
| cmd_lo | input | NPH | Low-side PWM command per phase |
| force_off | input | NPH | Fault force-off per phase |
| gate_hi | output | NPH | High-side gate enable per phase |
| gate_lo | output | NPH | Low-side gate enable per phase |

## Verification
The hardest case to reach is a retarget that lands inside a running dead interval. The new command must first get through the deglitch filter, which delays it by GLITCH_CYC cycles. It must therefore be applied only a few cycles after the turn-off command, so that it reaches the state machine before the count finishes. The bench releases the high command and raises the low command five cycles later. It then expects a gap of five cycles plus the deadtime, which differs from the gap a design without the restart would produce. The clamp bounds are reached by reprogramming `dt_cycles` between changeovers and measuring each gap at the gates.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        TGT_OFF = 2'd0,
        TGT_HI  = 2'd1,
        TGT_LO  = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DEAD = 2'd1,
        ST_HI   = 2'd2,
        ST_LO   = 2'd3
    } st_e;
endpackage

// File: rtl/hb_deglitch.sv
module hb_deglitch #(
    parameter int GLITCH_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] run;

    // The output takes a new level only after GLITCH_CYC consecutive samples that differ from it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            run <= '0;
        end else if (d != q) begin
            if (run == LAST) begin
                q   <= d;
                run <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end else begin
            run <= '0;
        end
    end
endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  logic inv_mode,
    input  logic hi_f,
    input  logic lo_f,
    output tgt_e tgt
);
    logic lo_eff;

    always_comb begin
        lo_eff = lo_f ^ inv_mode;
        if (hi_f && lo_eff)
            tgt = TGT_OFF;
        else if (hi_f)
            tgt = TGT_HI;
        else if (lo_eff)
            tgt = TGT_LO;
        else
            tgt = TGT_OFF;
    end
endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
    import hb_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            force_off,
    input  tgt_e            tgt,
    input  logic [DT_W-1:0] dt_eff,
    output logic            gate_hi,
    output logic            gate_lo
);
    st_e             state, state_n;
    tgt_e            pend, pend_n;
    logic [DT_W-1:0] cnt, cnt_n;

    function automatic st_e settle(input tgt_e t);
        unique case (t)
            TGT_HI:  return ST_HI;
            TGT_LO:  return ST_LO;
            default: return ST_OFF;
        endcase
    endfunction

    // Next-state logic
    always_comb begin
        state_n = state;
        pend_n  = pend;
        cnt_n   = cnt;
        if (force_off) begin
            state_n = ST_DEAD;
            pend_n  = tgt;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (tgt != TGT_OFF)
                        state_n = settle(tgt);
                end
                ST_HI: begin
                    if (tgt != TGT_HI) begin
                        state_n = ST_DEAD;
                        pend_n  = tgt;
                        cnt_n   = '0;
                    end
                end
                ST_LO: begin
                    if (tgt != TGT_LO) begin
                        state_n = ST_DEAD;
                        pend_n  = tgt;
                        cnt_n   = '0;
                    end
                end
                ST_DEAD: begin
                    if (tgt != pend) begin
                        pend_n = tgt;
                        cnt_n  = '0;
                    end else if (cnt >= dt_eff - 1'b1) begin
                        state_n = settle(pend);
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DEAD;
            pend  <= TGT_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            pend  <= pend_n;
            cnt   <= cnt_n;
        end
    end

    // Outputs from state
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state)
            ST_HI:   gate_hi = 1'b1;
            ST_LO:   gate_lo = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hb_cmd_top.sv
module hb_cmd_top
    import hb_pkg::*;
#(
    parameter int NPH        = 2,
    parameter int DT_W       = 8,
    parameter int DT_MIN     = 20,
    parameter int DT_MAX     = 200,
    parameter int GLITCH_CYC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inv_mode,
    input  logic [DT_W-1:0] dt_cycles,
    input  logic [NPH-1:0]  cmd_hi,
    input  logic [NPH-1:0]  cmd_lo,
    input  logic [NPH-1:0]  force_off,
    output logic [NPH-1:0]  gate_hi,
    output logic [NPH-1:0]  gate_lo
);
    localparam logic [DT_W-1:0] DT_LO = DT_W'(DT_MIN);
    localparam logic [DT_W-1:0] DT_HI = DT_W'(DT_MAX);

    logic [DT_W-1:0] dt_eff;

    always_comb begin
        if (dt_cycles < DT_LO)
            dt_eff = DT_LO;
        else if (dt_cycles > DT_HI)
            dt_eff = DT_HI;
        else
            dt_eff = dt_cycles;
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic hi_f, lo_f;
        tgt_e tgt;

        hb_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt_hi (
            .clk(clk), .rst_n(rst_n), .d(cmd_hi[p]), .q(hi_f)
        );
        hb_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt_lo (
            .clk(clk), .rst_n(rst_n), .d(cmd_lo[p]), .q(lo_f)
        );
        hb_decode u_dec (
            .inv_mode(inv_mode), .hi_f(hi_f), .lo_f(lo_f), .tgt(tgt)
        );
        hb_phase_fsm #(.DT_W(DT_W)) u_fsm (
            .clk(clk), .rst_n(rst_n), .force_off(force_off[p]), .tgt(tgt),
            .dt_eff(dt_eff), .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p])
        );
    end
endmodule

// File: rtl/hb_cmd_checker.sv
module hb_cmd_checker #(
    parameter int NPH    = 2,
    parameter int DT_MIN = 20
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] force_off,
    input logic [NPH-1:0] gate_hi,
    input logic [NPH-1:0] gate_lo
);
    localparam int CW = $clog2(DT_MIN + 1);
    localparam logic [CW-1:0] SAT = CW'(DT_MIN);

    for (genvar p = 0; p < NPH; p++) begin : g_chk
        logic [CW-1:0] off_run;
        logic          seen;
        logic          last_hi;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_run <= '0;
                seen    <= 1'b0;
                last_hi <= 1'b0;
            end else if (gate_hi[p] || gate_lo[p]) begin
                off_run <= '0;
                seen    <= 1'b1;
                last_hi <= gate_hi[p];
            end else if (off_run != SAT) begin
                off_run <= off_run + 1'b1;
            end
        end

        assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[p] && gate_lo[p]));

        assert_gap_hi_to_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_lo[p]) && seen && last_hi) |-> (off_run >= SAT));

        assert_gap_lo_to_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hi[p]) && seen && !last_hi) |-> (off_run >= SAT));

        assert_force_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
            force_off[p] |=> (!gate_hi[p] && !gate_lo[p]));
    end
endmodule

bind hb_cmd_top hb_cmd_checker #(.NPH(NPH), .DT_MIN(DT_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_off(force_off),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/hb_cmd_top_tb_top.sv
module hb_cmd_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPH    = 2;
    localparam int DT_W   = 8;
    localparam int DT_MIN = 20;
    localparam int DT_MAX = 200;
    localparam int G      = 7;
    localparam int DT_RUN = 30;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            rst_n;
    logic            inv_mode;
    logic [DT_W-1:0] dt_cycles;
    logic [NPH-1:0]  cmd_hi, cmd_lo, force_off, gate_hi, gate_lo;

    hb_cmd_top #(.NPH(NPH), .DT_W(DT_W), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX),
                 .GLITCH_CYC(G)) dut_i (
        .clk(clk), .rst_n(rst_n), .inv_mode(inv_mode), .dt_cycles(dt_cycles),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .force_off(force_off),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic gout(input int p, input bit sel_hi);
        return sel_hi ? gate_hi[p] : gate_lo[p];
    endfunction

    task automatic wait_off(input int p, input bit sel_hi);
        int k = 0;
        while (gout(p, sel_hi) && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // Counts sampled cycles, starting now, in which the selected gate is still off
    task automatic count_off(input int p, input bit sel_hi, output int n);
        n = 0;
        while (!gout(p, sel_hi) && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(gate_hi == '0 && gate_lo == '0, "R10 outputs off in reset",
            int'({gate_hi, gate_lo}), 0);
    endtask

    task automatic t_latency;
        cmd_hi[0] = 1'b1;
        tick(G);
        chk(gate_hi[0] == 1'b0, "R11 not yet on after G edges", gate_hi[0], 0);
        tick(1);
        chk(gate_hi[0] == 1'b1, "R11/R1 high on after G+1 edges", gate_hi[0], 1);
        chk(gate_lo[0] == 1'b0, "R1 low stays off", gate_lo[0], 0);
    endtask

    task automatic t_noninv;
        int n;
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b1;
        wait_off(0, 1'b1);
        count_off(0, 1'b0, n);
        chk(n == DT_RUN, "R4 gap high to low", n, DT_RUN);
        chk(gate_lo[0] == 1'b1 && gate_hi[0] == 1'b0, "R1 low row", gate_lo[0], 1);
        cmd_hi[0] = 1'b1; cmd_lo[0] = 1'b0;
        wait_off(0, 1'b0);
        count_off(0, 1'b1, n);
        chk(n == DT_RUN, "R4 gap low to high", n, DT_RUN);
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b0;
        tick(60);
        chk(gate_hi[0] == 1'b0 && gate_lo[0] == 1'b0, "R1 both-low row",
            int'({gate_hi[0], gate_lo[0]}), 0);
        cmd_hi[0] = 1'b1; cmd_lo[0] = 1'b1;
        tick(60);
        chk(gate_hi[0] == 1'b0 && gate_lo[0] == 1'b0, "R3 both commands true",
            int'({gate_hi[0], gate_lo[0]}), 0);
        cmd_hi[0] = 1'b0;
        tick(60);
        chk(gate_lo[0] == 1'b1, "R1 low-only row", gate_lo[0], 1);
        cmd_lo[0] = 1'b0;
        tick(60);
    endtask

    task automatic t_deglitch;
        int bad = 0;
        cmd_hi[0] = 1'b1;
        tick(G - 1);
        cmd_hi[0] = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (gate_hi[0] || gate_lo[0]) bad++;
        end
        chk(bad == 0, "R6 short pulse ignored", bad, 0);
        cmd_hi[0] = 1'b1;
        tick(G);
        cmd_hi[0] = 1'b0;
        tick(1);
        chk(gate_hi[0] == 1'b1, "R6 minimum-width pulse accepted", gate_hi[0], 1);
        tick(60);
    endtask

    task automatic t_inverting;
        int n;
        inv_mode = 1'b1;
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b0;
        tick(60);
        chk(gate_lo[0] == 1'b1 && gate_hi[0] == 1'b0, "R2 row 00 low on",
            int'({gate_hi[0], gate_lo[0]}), 1);
        cmd_lo[0] = 1'b1;
        tick(60);
        chk(gate_lo[0] == 1'b0 && gate_hi[0] == 1'b0, "R2 row 01 off",
            int'({gate_hi[0], gate_lo[0]}), 0);
        cmd_hi[0] = 1'b1; cmd_lo[0] = 1'b0;
        tick(60);
        chk(gate_lo[0] == 1'b0 && gate_hi[0] == 1'b0, "R2 row 10 invalid off",
            int'({gate_hi[0], gate_lo[0]}), 0);
        cmd_lo[0] = 1'b1;
        tick(60);
        chk(gate_hi[0] == 1'b1 && gate_lo[0] == 1'b0, "R2 row 11 high on",
            int'({gate_hi[0], gate_lo[0]}), 2);
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b0;
        wait_off(0, 1'b1);
        count_off(0, 1'b0, n);
        chk(n == DT_RUN, "R7 shared line falling edge gap", n, DT_RUN);
        cmd_hi[0] = 1'b1; cmd_lo[0] = 1'b1;
        wait_off(0, 1'b0);
        count_off(0, 1'b1, n);
        chk(n == DT_RUN, "R7 shared line rising edge gap", n, DT_RUN);
        inv_mode = 1'b0;
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b1;
        tick(60);
    endtask

    task automatic t_clamp;
        int n;
        dt_cycles = 8'd5;
        cmd_hi[0] = 1'b1; cmd_lo[0] = 1'b0;
        wait_off(0, 1'b0);
        count_off(0, 1'b1, n);
        chk(n == DT_MIN, "R5 value 5 clamps up", n, DT_MIN);
        dt_cycles = 8'd0;
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b1;
        wait_off(0, 1'b1);
        count_off(0, 1'b0, n);
        chk(n == DT_MIN, "R5 value 0 uses minimum", n, DT_MIN);
        dt_cycles = 8'd250;
        cmd_hi[0] = 1'b1; cmd_lo[0] = 1'b0;
        wait_off(0, 1'b0);
        count_off(0, 1'b1, n);
        chk(n == DT_MAX, "R5 value 250 clamps down", n, DT_MAX);
        dt_cycles = 8'(DT_RUN);
        tick(5);
    endtask

    task automatic t_restart;
        int n;
        cmd_hi[0] = 1'b0;
        tick(5);
        cmd_lo[0] = 1'b1;
        wait_off(0, 1'b1);
        count_off(0, 1'b0, n);
        chk(n == 5 + DT_RUN, "R9 count restarts on retarget", n, 5 + DT_RUN);
    endtask

    task automatic t_force;
        int n;
        force_off[0] = 1'b1;
        tick(1);
        chk(gate_hi[0] == 1'b0 && gate_lo[0] == 1'b0, "R10 force-off next edge",
            int'({gate_hi[0], gate_lo[0]}), 0);
        tick(10);
        chk(gate_lo[0] == 1'b0, "R10 force-off held", gate_lo[0], 0);
        force_off[0] = 1'b0;
        count_off(0, 1'b0, n);
        chk(n == DT_RUN, "R10 resume through full deadtime", n, DT_RUN);
    endtask

    task automatic t_indep;
        int bad = 0;
        cmd_hi[1] = 1'b1;
        for (int i = 0; i < 40; i++) begin tick(1); if (gate_lo[0] !== 1'b1) bad++; end
        cmd_hi[1] = 1'b0; cmd_lo[1] = 1'b1;
        for (int i = 0; i < 60; i++) begin tick(1); if (gate_lo[0] !== 1'b1) bad++; end
        force_off[1] = 1'b1;
        for (int i = 0; i < 10; i++) begin tick(1); if (gate_lo[0] !== 1'b1) bad++; end
        force_off[1] = 1'b0; cmd_lo[1] = 1'b0;
        for (int i = 0; i < 60; i++) begin tick(1); if (gate_lo[0] !== 1'b1) bad++; end
        chk(bad == 0, "R8 phase 0 undisturbed by phase 1", bad, 0);
        cmd_lo[0] = 1'b0;
        tick(60);
        cmd_hi = '1;
        tick(G);
        chk(gate_hi == 2'b00, "R8 matched latency before", int'(gate_hi), 0);
        tick(1);
        chk(gate_hi == 2'b11, "R8 matched latency both on", int'(gate_hi), 3);
    endtask

    initial begin
        rst_n = 1'b0; inv_mode = 1'b0; dt_cycles = 8'(DT_RUN);
        cmd_hi = '0; cmd_lo = '0; force_off = '0;
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(60);
        t_latency();
        t_noninv();
        t_deglitch();
        t_inverting();
        t_clamp();
        t_restart();
        t_force();
        t_indep();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule